// File: doc/BRIEF.md
# Hierarchical Full-Map Directory Entry Controller

This block controls one entry of a directory that sits at an intermediate level of a tree-shaped cache coherence hierarchy. It keeps a presence vector with one bit per child subtree and shows which children hold a copy of the block. It also keeps an acknowledgement counter and a state register. Three status bits, dirty, transient and invalidating, follow from the state alone. Message transport and data payload are handled elsewhere. This controller only decides state, presence, upward requests, downward invalidations and the acknowledgement bookkeeping.

Children present read or write requests, together with their index. A read records the requester and asks the parent for the block. A write does three things: it asks the parent for ownership, it sends one invalidation pulse to every other child that holds a copy, and it counts their acknowledgements. The entry settles with the writer as the only holder once the grant and all the acknowledgements have arrived. The parent can invalidate the whole subtree. The entry then clears its presence bits, invalidates every holder, waits for all the acknowledgements, and acknowledges upward for one cycle. While a transient state is active, nothing new is accepted.

Top module: `hdir_entry_ctrl`

## Requirements
- R1: After reset the state is ABS (code 0), the presence vector and acknowledgement count are zero, and the outputs up_req_valid_o, up_ack_o, inv_o, dirty_o, tr_o and inv_flag_o are all low.
- R2: The status bits follow from the state. The state codes are ABS=0, ABT=1, RO=2, RW=3, RT=4, WT=5 and INV=6. dirty_o is high only in RW and WT. tr_o is high only in RT, WT and INV. inv_flag_o is high only in INV. The presence vector is zero in ABS, ABT and INV, and nonzero in the other states.
- R3: In ABS, ABT, RO or RW, an accepted child read (creq_wr_i=0) has the following effects:
  - It sets the requester's presence bit and enters RT.
  - up_req_valid_o is high with up_req_wr_o low until pgnt_i.
  - pgnt_i moves the entry to RO and keeps the presence vector.
- R4: An accepted child write (creq_wr_i=1) has the following effects:
  - It enters WT and sets the requester's presence bit.
  - It drives inv_o for one cycle with the other present children's bits.
  - It loads the acknowledgement count with the number of those children.
  - up_req_valid_o and up_req_wr_o are high until the grant.
- R5: WT moves to RW once a grant has been seen and the count is zero, in either order. In RW only the requester's presence bit is set. If no other child held a copy, the grant alone completes the write.
- R6: When tr_o is low, pinv_valid_i clears the presence vector and drives inv_o for one cycle with the former presence bits. It also loads the count with their number and enters INV. If no child held a copy, it enters ABT directly.
- R7: Each cack_i bit of a child that is still pending decrements the count once, and several bits in one cycle decrement it by their number. Bits from children that are not pending are ignored.
- R8: When the count reaches zero in INV, the entry spends one cycle in ABT with up_ack_o high, then returns to ABS unless a new request is accepted there.
- R9: While tr_o is high, child requests and parent invalidations are not accepted and stall_o is high for them. When a parent invalidation and a child request arrive together, the invalidation wins and stall_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| creq_valid_i | input | 1 | Child request present |
| creq_wr_i | input | 1 | Child request is a write (1) or read (0) |
| creq_id_i | input | IDW | Index of requesting child |
| pinv_valid_i | input | 1 | Invalidate request from parent |
| pgnt_i | input | 1 | Grant from parent for the outstanding upward request |
| cack_i | input | NUM_CHILD | Per-child invalidation acknowledgement |
| stall_o | output | 1 | Presented request not accepted this cycle |
| up_req_valid_o | output | 1 | Upward request outstanding |
| up_req_wr_o | output | 1 | Upward request asks for ownership |
| up_ack_o | output | 1 | Subtree invalidation complete, to parent |
| inv_o | output | NUM_CHILD | One-cycle invalidation pulse per child |
| state_o | output | 3 | Current state code |
| pres_o | output | NUM_CHILD | Descendant presence vector |
| dirty_o | output | 1 | Dirty status bit |
| tr_o | output | 1 | Transient status bit |
| inv_flag_o | output | 1 | Invalidating status bit |
| ack_cnt_o | output | CNTW | Outstanding acknowledgement count |

## Verification
The assertions check the following on every cycle:
- the presence vector is empty in the absent and invalidating states and non-empty in the others;
- RW has exactly one holder;
- invalidation pulses appear only together with the transient bit;
- the count always equals the number of children still pending;
- the counter is loaded only when nothing is pending;
- RT holds until a grant arrives.

Only the bench scenarios can show the following:
- the relative order of grant and acknowledgements in a write;
- that acknowledgements from children that are not pending are ignored;
- that several acknowledgements in one cycle are counted together;
- the arbitration of a parent invalidation against a child request;
- that a request arriving in the one-cycle ABT state is accepted.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
  typedef enum logic [2:0] {
    ST_ABS = 3'd0,
    ST_ABT = 3'd1,
    ST_RO  = 3'd2,
    ST_RW  = 3'd3,
    ST_RT  = 3'd4,
    ST_WT  = 3'd5,
    ST_INV = 3'd6
  } hdir_state_e;

  typedef struct packed {
    logic dirty;
    logic tr;
    logic inv;
  } hdir_flags_t;
endpackage

// File: rtl/hdir_state_flags.sv
module hdir_state_flags
  import hdir_pkg::*;
(
  input  hdir_state_e state_i,
  output hdir_flags_t flags_o
);
  always_comb begin
    flags_o = '0;
    unique case (state_i)
      ST_RW:   flags_o.dirty = 1'b1;
      ST_RT:   flags_o.tr    = 1'b1;
      ST_WT:   begin flags_o.dirty = 1'b1; flags_o.tr = 1'b1; end
      ST_INV:  begin flags_o.tr    = 1'b1; flags_o.inv = 1'b1; end
      default: flags_o = '0;
    endcase
  end
endmodule

// File: rtl/hdir_ack_counter.sv
module hdir_ack_counter #(
  parameter  int unsigned NUM_CHILD = 4,
  localparam int unsigned CNTW      = $clog2(NUM_CHILD + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [NUM_CHILD-1:0] load_mask_i,
  input  logic [NUM_CHILD-1:0] ack_i,
  output logic [CNTW-1:0]      cnt_o,
  output logic                 zero_nxt_o
);
  logic [NUM_CHILD-1:0] pend_q;
  logic [CNTW-1:0]      cnt_q;
  logic [NUM_CHILD-1:0] hit;
  logic [CNTW-1:0]      dec, ld_cnt;

  assign hit = ack_i & pend_q;

  always_comb begin
    dec    = '0;
    ld_cnt = '0;
    for (int i = 0; i < NUM_CHILD; i++) begin
      dec    = dec + CNTW'(hit[i]);
      ld_cnt = ld_cnt + CNTW'(load_mask_i[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      pend_q <= load_mask_i;
      cnt_q  <= ld_cnt;
    end else begin
      pend_q <= pend_q & ~ack_i;
      cnt_q  <= cnt_q - dec;
    end
  end

  assign cnt_o      = cnt_q;
  assign zero_nxt_o = (cnt_q - dec) == '0;

  // R7
  cnt_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) == $countones(pend_q));
  // R7
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> pend_q == '0);
endmodule

// File: rtl/hdir_entry_ctrl.sv
module hdir_entry_ctrl
  import hdir_pkg::*;
#(
  parameter  int unsigned NUM_CHILD = 4,
  localparam int unsigned IDW       = $clog2(NUM_CHILD),
  localparam int unsigned CNTW      = $clog2(NUM_CHILD + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 creq_valid_i,
  input  logic                 creq_wr_i,
  input  logic [IDW-1:0]       creq_id_i,
  input  logic                 pinv_valid_i,
  input  logic                 pgnt_i,
  input  logic [NUM_CHILD-1:0] cack_i,
  output logic                 stall_o,
  output logic                 up_req_valid_o,
  output logic                 up_req_wr_o,
  output logic                 up_ack_o,
  output logic [NUM_CHILD-1:0] inv_o,
  output logic [2:0]           state_o,
  output logic [NUM_CHILD-1:0] pres_o,
  output logic                 dirty_o,
  output logic                 tr_o,
  output logic                 inv_flag_o,
  output logic [CNTW-1:0]      ack_cnt_o
);
  hdir_state_e          state_q, state_d;
  logic [NUM_CHILD-1:0] pres_q, pres_d;
  logic [NUM_CHILD-1:0] req_q, req_d;
  logic [NUM_CHILD-1:0] inv_q, inv_d;
  logic                 gnt_q, gnt_d;
  hdir_flags_t          flags;
  logic [NUM_CHILD-1:0] req_oh;
  logic                 take_pinv, take_req, ld, zero_nxt;
  logic [NUM_CHILD-1:0] ld_mask;

  hdir_state_flags u_flags (
    .state_i (state_q),
    .flags_o (flags)
  );

  assign req_oh    = NUM_CHILD'(1) << creq_id_i;
  assign take_pinv = !flags.tr && pinv_valid_i;
  assign take_req  = !flags.tr && creq_valid_i && !pinv_valid_i;
  assign ld        = take_pinv || (take_req && creq_wr_i);
  assign ld_mask   = take_pinv ? pres_q : (pres_q & ~req_oh);

  hdir_ack_counter #(.NUM_CHILD(NUM_CHILD)) u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (ld),
    .load_mask_i (ld_mask),
    .ack_i       (cack_i),
    .cnt_o       (ack_cnt_o),
    .zero_nxt_o  (zero_nxt)
  );

  always_comb begin
    state_d = state_q;
    pres_d  = pres_q;
    req_d   = req_q;
    gnt_d   = gnt_q;
    inv_d   = '0;
    unique case (state_q)
      ST_RT: if (pgnt_i) state_d = ST_RO;
      ST_WT: begin
        gnt_d = gnt_q | pgnt_i;
        if ((gnt_q || pgnt_i) && zero_nxt) begin
          state_d = ST_RW;
          pres_d  = req_q;
          gnt_d   = 1'b0;
        end
      end
      ST_INV: if (zero_nxt) state_d = ST_ABT;
      default: begin
        if (take_pinv) begin
          inv_d   = pres_q;
          pres_d  = '0;
          state_d = (pres_q == '0) ? ST_ABT : ST_INV;
        end else if (take_req) begin
          pres_d = pres_q | req_oh;
          if (creq_wr_i) begin
            inv_d   = pres_q & ~req_oh;
            req_d   = req_oh;
            gnt_d   = 1'b0;
            state_d = ST_WT;
          end else begin
            state_d = ST_RT;
          end
        end else if (state_q == ST_ABT) begin
          state_d = ST_ABS;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ABS;
      pres_q  <= '0;
      req_q   <= '0;
      inv_q   <= '0;
      gnt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pres_q  <= pres_d;
      req_q   <= req_d;
      inv_q   <= inv_d;
      gnt_q   <= gnt_d;
    end
  end

  assign stall_o        = (flags.tr && (creq_valid_i || pinv_valid_i)) ||
                          (creq_valid_i && pinv_valid_i);
  assign up_req_valid_o = (state_q == ST_RT || state_q == ST_WT) && !gnt_q;
  assign up_req_wr_o    = state_q == ST_WT;
  assign up_ack_o       = state_q == ST_ABT;
  assign inv_o          = inv_q;
  assign state_o        = state_q;
  assign pres_o         = pres_q;
  assign dirty_o        = flags.dirty;
  assign tr_o           = flags.tr;
  assign inv_flag_o     = flags.inv;

  // R2
  pres_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ABS || state_q == ST_ABT || state_q == ST_INV) |-> pres_q == '0);
  // R2
  pres_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RO || state_q == ST_RW || state_q == ST_RT || state_q == ST_WT)
      |-> pres_q != '0);
  // R5
  rw_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RW |-> $countones(pres_q) == 1);
  // R4
  inv_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_q != '0 |-> flags.tr);
  // R3
  rt_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RT && !pgnt_i) |=> state_q == ST_RT);
  // R9
  tr_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags.tr && creq_valid_i) |-> stall_o);
endmodule

// File: tb/tb_hdir_entry_ctrl.sv
`timescale 1ns/1ps
module tb_hdir_entry_ctrl;
  localparam int K = 4;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cv = 1'b0, cw = 1'b0, pv = 1'b0, gnt = 1'b0;
  logic [1:0]   cid = '0;
  logic [K-1:0] ack = '0;
  logic         stall, upv, upw, upa, dirty, tr, invf;
  logic [K-1:0] inv, pres;
  logic [2:0]   st;
  logic [2:0]   cnt;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // behavioural reference
  int           m_st = 0;
  logic [K-1:0] m_pres = '0, m_inv = '0;
  int           m_pend[$];
  bit           m_gnt = 0;
  int           m_req = 0;

  hdir_entry_ctrl #(.NUM_CHILD(K)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .creq_valid_i(cv), .creq_wr_i(cw),
    .creq_id_i(cid), .pinv_valid_i(pv), .pgnt_i(gnt), .cack_i(ack),
    .stall_o(stall), .up_req_valid_o(upv), .up_req_wr_o(upw), .up_ack_o(upa),
    .inv_o(inv), .state_o(st), .pres_o(pres), .dirty_o(dirty), .tr_o(tr),
    .inv_flag_o(invf), .ack_cnt_o(cnt)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_bad++;
      $display("FAIL watchdog expired got %0d cycles exp below 5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(string tag, string fld, int got, int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0d exp %0d", tag, fld, got, exp);
    end
  endtask

  task automatic drop_acks();
    int keep[$];
    foreach (m_pend[j]) if (!ack[m_pend[j]]) keep.push_back(m_pend[j]);
    m_pend = keep;
  endtask

  task automatic model_step();
    bit busy = (m_st >= 4);
    m_inv = '0;
    if (!busy) begin
      if (pv) begin
        m_pend.delete();
        for (int i = 0; i < K; i++) if (m_pres[i]) m_pend.push_back(i);
        m_inv  = m_pres;
        m_pres = '0;
        m_st   = (m_pend.size() > 0) ? 6 : 1;
      end else if (cv) begin
        if (cw) begin
          m_pend.delete();
          for (int i = 0; i < K; i++) if (m_pres[i] && i != int'(cid)) m_pend.push_back(i);
          m_inv = m_pres;
          m_inv[cid] = 1'b0;
          m_pres[cid] = 1'b1;
          m_req = int'(cid);
          m_gnt = 0;
          m_st  = 5;
        end else begin
          m_pres[cid] = 1'b1;
          m_st = 4;
        end
      end else if (m_st == 1) begin
        m_st = 0;
      end
    end else if (m_st == 4) begin
      if (gnt) m_st = 2;
    end else begin
      drop_acks();
      if (m_st == 5) begin
        if (gnt) m_gnt = 1;
        if (m_gnt && m_pend.size() == 0) begin
          m_st = 3;
          m_pres = '0;
          m_pres[m_req] = 1'b1;
          m_gnt = 0;
        end
      end else if (m_pend.size() == 0) begin
        m_st = 1;
      end
    end
  endtask

  task automatic compare(string tag);
    bit e_tr = (m_st >= 4);
    chk(tag, "state", int'(st), m_st);
    chk(tag, "pres", int'(pres), int'(m_pres));
    chk(tag, "inv_o", int'(inv), int'(m_inv));
    chk(tag, "up_req_valid", int'(upv), int'((m_st == 4 || m_st == 5) && !m_gnt));
    chk(tag, "up_req_wr", int'(upw), int'(m_st == 5));
    chk("R2", "dirty", int'(dirty), int'(m_st == 3 || m_st == 5));
    chk("R2", "tr", int'(tr), int'(e_tr));
    chk("R2", "inv_flag", int'(invf), int'(m_st == 6));
    chk("R7", "ack_cnt", int'(cnt), m_pend.size());
    chk("R8", "up_ack", int'(upa), int'(m_st == 1));
    chk("R9", "stall", int'(stall), int'((e_tr && (cv || pv)) || (cv && pv)));
  endtask

  task automatic step(string tag, bit v, bit w, int id, bit p, logic [K-1:0] a, bit g);
    cv = v; cw = w; cid = 2'(id); pv = p; ack = a; gnt = g;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
    idle("R1");

    // R3 read from ABS, wait, grant
    step("R3", 1, 0, 1, 0, '0, 0);
    idle("R3");
    step("R3", 0, 0, 0, 0, '0, 1);
    // R3 second reader from RO
    step("R3", 1, 0, 2, 0, '0, 0);
    // R9 requests during RT are held off
    step("R9", 1, 1, 3, 0, '0, 0);
    step("R9", 0, 0, 0, 1, '0, 0);
    step("R3", 0, 0, 0, 0, '0, 1);

    // R4 write by child 0 with holders 1,2
    step("R4", 1, 1, 0, 0, '0, 0);
    step("R7", 0, 0, 0, 0, 4'b0010, 0);
    step("R7", 0, 0, 0, 0, 4'b1000, 0);
    step("R5", 0, 0, 0, 0, '0, 1);
    idle("R5");
    step("R5", 0, 0, 0, 0, 4'b0100, 0);
    idle("R5");

    // R5 write by child 3 from RW, acks before grant
    step("R4", 1, 1, 3, 0, '0, 0);
    step("R5", 0, 0, 0, 0, 4'b0001, 0);
    step("R5", 0, 0, 0, 0, '0, 1);

    // R9 parent invalidate beats child read
    step("R9", 1, 0, 1, 1, '0, 0);
    step("R6", 0, 0, 0, 0, '0, 0);
    step("R8", 0, 0, 0, 0, 4'b1000, 0);
    idle("R8");
    idle("R8");

    // R8 invalidate with no holders, then read accepted in ABT
    step("R8", 0, 0, 0, 1, '0, 0);
    step("R3", 1, 0, 2, 0, '0, 0);
    step("R3", 0, 0, 0, 0, '0, 1);
    // R5 sole holder upgrade: grant alone completes
    step("R5", 1, 1, 2, 0, '0, 0);
    step("R5", 0, 0, 0, 0, '0, 1);

    // R7 several acks in one cycle
    step("R3", 1, 0, 0, 0, '0, 0);
    step("R3", 0, 0, 0, 0, '0, 1);
    step("R3", 1, 0, 1, 0, '0, 0);
    step("R3", 0, 0, 0, 0, '0, 1);
    step("R6", 0, 0, 0, 1, '0, 0);
    step("R7", 0, 0, 0, 0, 4'b0011, 0);
    step("R7", 0, 0, 0, 0, 4'b0100, 0);
    idle("R8");
    idle("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule